// File: doc/BRIEF.md
# Addressed Counter Bank with Immediate Operators

This block holds a large number of up/down event counters for a controller whose program drives them one at a time. Per-counter flip-flops are not used. The running count, the preset and the last seen level of each counting input all live in addressed memories. One shared execution path serves whichever counter the address selects.

The controller supplies five things: a one-bit accumulator value, a word accumulator value, a counter address and a set of one-hot operation enables. Each operation updates the addressed counter in the same clock cycle. No separate call step is needed.

The two status flags and the count of the addressed counter are always visible at the outputs. They are formed by logic from the memory read values and are not stored.

Top module: `ctr_bank`

## Requirements
- R1: A synchronous active-high reset clears every count, every preset and every stored input level to zero. After reset, any address reads count 0 with both flags at 1, and the first count-up with the bit input at 1 counts.
- R2: The count-up operation (op_en bit 0) increments the addressed count when the bit input is 1 and the stored up-level for that address is 0.
- R3: Every count-up operation stores the bit input as that counter's up-level. A count-up with the bit at 1 and a stored level of 1, or with the bit at 0, leaves the count unchanged.
- R4: The count-down operation (op_en bit 1) decrements on the same rising-edge rule. It uses its own stored down-level, separate from the up-level.
- R5: Counts are signed two's complement of CW bits. A count-up at the maximum (2^(CW-1)-1) or a count-down at the minimum (-2^(CW-1)) leaves the count unchanged.
- R6: The clear operation (op_en bit 2) sets the count to 0 when the bit input is 1. When the bit input is 0 the count is not changed.
- R7: The load operation (op_en bit 3) copies the addressed preset into the count when the bit input is 1. When the bit input is 0 the count is not changed.
- R8: The preset operation (op_en bit 4) writes the word input into the addressed preset and leaves the count unchanged.
- R9: qu_out is 1 exactly when the addressed count is greater than or equal to the addressed preset, compared as signed values.
- R10: qd_out is 1 exactly when the addressed count is less than or equal to zero.
- R11: An operation changes only the counter at its address.
- R12: At most one operation enable is active per cycle. Each operation's effect is visible at the outputs from the clock edge that executes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_acc | input | 1 | Bit accumulator value |
| word_acc | input | CW | Word accumulator value (preset source) |
| addr | input | AW | Counter address |
| op_en | input | 5 | One-hot enables: 0 up, 1 down, 2 clear, 3 load, 4 preset |
| cv_out | output | CW | Count of the addressed counter (signed) |
| qu_out | output | 1 | Count reached preset |
| qd_out | output | 1 | Count at or below zero |

## Verification
A corrupted count or preset word appears on cv_out or on the flags as soon as the address selects that counter; no clock edge is needed, because the read path is combinational. A wrong stored input level is hidden until the next count operation at that address. It then shows up one edge later as a missed or extra step. For this reason the stimulus alternates the bit input between levels and revisits addresses. Saturation and signed comparison are exercised by loading presets near both limits and below zero.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  localparam int NUM_OPS = 5;
  localparam int OP_UP  = 0;
  localparam int OP_DN  = 1;
  localparam int OP_CLR = 2;
  localparam int OP_LD  = 3;
  localparam int OP_PV  = 4;

  typedef enum logic [2:0] {
    NX_HOLD, NX_INC, NX_DEC, NX_ZERO, NX_PRESET
  } next_sel_t;
endpackage

// File: rtl/ctr_mem.sv
module ctr_mem #(
  parameter int DEPTH = 64,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [DEPTH];

  // Asynchronous read, synchronous write, cleared as a whole on reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else if (we) begin
      store[addr] <= wdata;
    end
  end

  assign rdata = store[addr];
endmodule

// File: rtl/ctr_exec.sv
module ctr_exec
  import ctr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                 bit_acc,
  input  logic [CW-1:0]        word_acc,
  input  logic [NUM_OPS-1:0]   op_en,
  input  logic signed [CW-1:0] cv_rd,
  input  logic signed [CW-1:0] pv_rd,
  input  logic                 up_lvl,
  input  logic                 dn_lvl,
  output logic                 cv_we,
  output logic signed [CW-1:0] cv_wd,
  output logic                 pv_we,
  output logic [CW-1:0]        pv_wd,
  output logic                 up_we,
  output logic                 dn_we,
  output logic                 lvl_wd
);
  localparam logic signed [CW-1:0] MAXV = {1'b0, {(CW-1){1'b1}}};
  localparam logic signed [CW-1:0] MINV = {1'b1, {(CW-1){1'b0}}};
  localparam logic signed [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

  next_sel_t sel;
  logic up_edge, dn_edge, at_max, at_min;

  assign up_edge = bit_acc & ~up_lvl;
  assign dn_edge = bit_acc & ~dn_lvl;
  assign at_max  = (cv_rd == MAXV);
  assign at_min  = (cv_rd == MINV);

  always_comb begin
    sel = NX_HOLD;
    if (op_en[OP_CLR]) begin
      if (bit_acc) sel = NX_ZERO;
    end else if (op_en[OP_LD]) begin
      if (bit_acc) sel = NX_PRESET;
    end else if (op_en[OP_UP]) begin
      if (up_edge && !at_max) sel = NX_INC;
    end else if (op_en[OP_DN]) begin
      if (dn_edge && !at_min) sel = NX_DEC;
    end
  end

  always_comb begin
    case (sel)
      NX_INC:    cv_wd = cv_rd + ONE;
      NX_DEC:    cv_wd = cv_rd - ONE;
      NX_ZERO:   cv_wd = '0;
      NX_PRESET: cv_wd = pv_rd;
      default:   cv_wd = cv_rd;
    endcase
  end

  assign cv_we  = (sel != NX_HOLD);
  assign pv_we  = op_en[OP_PV];
  assign pv_wd  = word_acc;
  assign up_we  = op_en[OP_UP];
  assign dn_we  = op_en[OP_DN];
  assign lvl_wd = bit_acc;
endmodule

// File: rtl/ctr_bank.sv
module ctr_bank
  import ctr_pkg::*;
#(
  parameter int N_CTR = 64,
  parameter int CW    = 16,
  localparam int AW   = $clog2(N_CTR)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_acc,
  input  logic [CW-1:0]        word_acc,
  input  logic [AW-1:0]        addr,
  input  logic [NUM_OPS-1:0]   op_en,
  output logic signed [CW-1:0] cv_out,
  output logic                 qu_out,
  output logic                 qd_out
);
  localparam logic signed [CW-1:0] MAXV = {1'b0, {(CW-1){1'b1}}};
  localparam logic signed [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

  logic signed [CW-1:0] cv_rd, cv_wd, pv_rd_s;
  logic [CW-1:0] pv_rd, pv_wd, cv_rd_u;
  logic cv_we, pv_we, up_we, dn_we, lvl_wd;
  logic [1:0] lvl_we, lvl_rd;

  ctr_mem #(.DEPTH(N_CTR), .W(CW)) u_cv_mem (
    .clk(clk), .rst(rst), .we(cv_we), .addr(addr),
    .wdata(cv_wd), .rdata(cv_rd_u));

  ctr_mem #(.DEPTH(N_CTR), .W(CW)) u_pv_mem (
    .clk(clk), .rst(rst), .we(pv_we), .addr(addr),
    .wdata(pv_wd), .rdata(pv_rd));

  assign lvl_we = {dn_we, up_we};

  // One level memory per counting direction: index 0 up, 1 down.
  for (genvar d = 0; d < 2; d++) begin : g_lvl
    ctr_mem #(.DEPTH(N_CTR), .W(1)) u_lvl_mem (
      .clk(clk), .rst(rst), .we(lvl_we[d]), .addr(addr),
      .wdata(lvl_wd), .rdata(lvl_rd[d]));
  end

  assign cv_rd   = cv_rd_u;
  assign pv_rd_s = pv_rd;

  ctr_exec #(.CW(CW)) u_exec (
    .bit_acc(bit_acc), .word_acc(word_acc), .op_en(op_en),
    .cv_rd(cv_rd), .pv_rd(pv_rd_s), .up_lvl(lvl_rd[0]), .dn_lvl(lvl_rd[1]),
    .cv_we(cv_we), .cv_wd(cv_wd), .pv_we(pv_we), .pv_wd(pv_wd),
    .up_we(up_we), .dn_we(dn_we), .lvl_wd(lvl_wd));

  assign cv_out = cv_rd;
  assign qu_out = (cv_rd >= pv_rd_s);
  assign qd_out = (cv_rd <= 0);

  assert_ops_onehot_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(op_en));

  assert_up_step_R2: assert property (@(posedge clk) disable iff (rst)
    (op_en == 5'b00001 && bit_acc && !lvl_rd[0] && cv_out != MAXV)
    |=> (addr != $past(addr) || cv_out == $past(cv_out) + ONE));

  assert_max_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (op_en == 5'b00001 && cv_out == MAXV)
    |=> (addr != $past(addr) || cv_out == MAXV));

  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (op_en == 5'b00100 && bit_acc)
    |=> (addr != $past(addr) || cv_out == '0));

  assert_gate_hold_R7: assert property (@(posedge clk) disable iff (rst)
    ((op_en == 5'b00100 || op_en == 5'b01000) && !bit_acc)
    |=> (addr != $past(addr) || $stable(cv_out)));

  assert_preset_wr_R8: assert property (@(posedge clk) disable iff (rst)
    (op_en == 5'b10000)
    |=> (addr != $past(addr) || (pv_rd == $past(word_acc) && $stable(cv_out))));
endmodule

// File: tb/ctr_bank_test.sv
module ctr_bank_test;
  localparam int CW = 16;
  localparam int AW = 6;
  localparam int NV = 22;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_acc = 1'b0;
  logic [CW-1:0] word_acc = '0;
  logic [AW-1:0] addr = '0;
  logic [4:0] op_en = '0;
  logic signed [CW-1:0] cv_out;
  logic qu_out, qd_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ctr_bank #(.N_CTR(64), .CW(CW)) uut (
    .clk(clk), .rst(rst), .bit_acc(bit_acc), .word_acc(word_acc),
    .addr(addr), .op_en(op_en), .cv_out(cv_out), .qu_out(qu_out), .qd_out(qd_out));

  // Row: op[45:41] bit[40] word[39:24] addr[23:18] cv[17:2] qu[1] qd[0]
  localparam logic [45:0] VEC [NV] = '{
    {5'b10000, 1'b0, 16'd3,      6'd3, 16'd0,      1'b0, 1'b1}, // R8 preset 3
    {5'b00001, 1'b1, 16'd0,      6'd3, 16'd1,      1'b0, 1'b0}, // R2 edge counts
    {5'b00001, 1'b1, 16'd0,      6'd3, 16'd1,      1'b0, 1'b0}, // R3 level held
    {5'b00001, 1'b0, 16'd0,      6'd3, 16'd1,      1'b0, 1'b0}, // R3 low stored
    {5'b00001, 1'b1, 16'd0,      6'd3, 16'd2,      1'b0, 1'b0}, // R2
    {5'b00001, 1'b0, 16'd0,      6'd3, 16'd2,      1'b0, 1'b0}, // R3
    {5'b00001, 1'b1, 16'd0,      6'd3, 16'd3,      1'b1, 1'b0}, // R9 reaches preset
    {5'b00010, 1'b1, 16'd0,      6'd3, 16'd2,      1'b0, 1'b0}, // R4 own level
    {5'b00010, 1'b1, 16'd0,      6'd3, 16'd2,      1'b0, 1'b0}, // R4 held
    {5'b00010, 1'b0, 16'd0,      6'd3, 16'd2,      1'b0, 1'b0}, // R4
    {5'b00010, 1'b1, 16'd0,      6'd3, 16'd1,      1'b0, 1'b0}, // R4
    {5'b00100, 1'b0, 16'd0,      6'd3, 16'd1,      1'b0, 1'b0}, // R6 gated off
    {5'b00100, 1'b1, 16'd0,      6'd3, 16'd0,      1'b0, 1'b1}, // R6 clear
    {5'b01000, 1'b0, 16'd0,      6'd3, 16'd0,      1'b0, 1'b1}, // R7 gated off
    {5'b01000, 1'b1, 16'd0,      6'd3, 16'd3,      1'b1, 1'b0}, // R7 load
    {5'b00000, 1'b0, 16'd0,      6'd5, 16'd0,      1'b1, 1'b1}, // R11 other untouched
    {5'b00001, 1'b1, 16'd0,      6'd5, 16'd1,      1'b1, 1'b0}, // R11 count at 5
    {5'b00000, 1'b0, 16'd0,      6'd3, 16'd3,      1'b1, 1'b0}, // R11 3 kept
    {5'b10000, 1'b0, 16'hFFFE,   6'd3, 16'd3,      1'b1, 1'b0}, // R9 signed compare
    {5'b01000, 1'b1, 16'd0,      6'd3, 16'hFFFE,   1'b1, 1'b1}, // R10 negative
    {5'b00010, 1'b0, 16'd0,      6'd3, 16'hFFFE,   1'b1, 1'b1}, // R4
    {5'b00010, 1'b1, 16'd0,      6'd3, 16'hFFFD,   1'b0, 1'b1}  // R10 R12
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step(input logic [4:0] op, input logic b, input logic [CW-1:0] w,
                      input logic [AW-1:0] a);
    op_en = op; bit_acc = b; word_acc = w; addr = a;
    @(negedge clk);
  endtask

  task automatic look(input string req, input logic [AW-1:0] a,
                      input logic [CW-1:0] cv, input logic qu, input logic qd);
    op_en = '0; addr = a;
    #1;
    chk({req, " cv"}, {16'b0, cv_out}, {16'b0, cv});
    chk({req, " qu"}, {31'b0, qu_out}, {31'b0, qu});
    chk({req, " qd"}, {31'b0, qd_out}, {31'b0, qd});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    look("R1 reset a0", 6'd0, 16'd0, 1'b1, 1'b1);
    look("R1 reset a63", 6'd63, 16'd0, 1'b1, 1'b1);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][45:41], VEC[i][40], VEC[i][39:24], VEC[i][23:18]);
      chk($sformatf("table row %0d cv", i), {16'b0, cv_out}, {16'b0, VEC[i][17:2]});
      chk($sformatf("table row %0d qu", i), {31'b0, qu_out}, {31'b0, VEC[i][1]});
      chk($sformatf("table row %0d qd", i), {31'b0, qd_out}, {31'b0, VEC[i][0]});
    end

    // R5 upper saturation
    step(5'b10000, 1'b0, 16'h7FFE, 6'd7);
    step(5'b01000, 1'b1, 16'd0, 6'd7);
    step(5'b00001, 1'b1, 16'd0, 6'd7);
    look("R5 reach max", 6'd7, 16'h7FFF, 1'b1, 1'b0);
    step(5'b00001, 1'b0, 16'd0, 6'd7);
    step(5'b00001, 1'b1, 16'd0, 6'd7);
    look("R5 hold max", 6'd7, 16'h7FFF, 1'b1, 1'b0);

    // R5 lower saturation
    step(5'b10000, 1'b0, 16'h8001, 6'd8);
    step(5'b01000, 1'b1, 16'd0, 6'd8);
    step(5'b00010, 1'b1, 16'd0, 6'd8);
    look("R5 reach min", 6'd8, 16'h8000, 1'b0, 1'b1);
    step(5'b00010, 1'b0, 16'd0, 6'd8);
    step(5'b00010, 1'b1, 16'd0, 6'd8);
    look("R5 hold min", 6'd8, 16'h8000, 1'b0, 1'b1);

    // R8 preset leaves count alone
    step(5'b10000, 1'b0, 16'd100, 6'd7);
    look("R8 count kept", 6'd7, 16'h7FFF, 1'b1, 1'b0);

    // R1 reset clears counts, presets and levels
    rst = 1'b1;
    step(5'b00000, 1'b0, 16'd0, 6'd0);
    step(5'b00000, 1'b0, 16'd0, 6'd0);
    rst = 1'b0;
    look("R1 after reset a3", 6'd3, 16'd0, 1'b1, 1'b1);
    look("R1 after reset a7", 6'd7, 16'd0, 1'b1, 1'b1);
    step(5'b00001, 1'b1, 16'd0, 6'd3);
    look("R1 level cleared", 6'd3, 16'd1, 1'b1, 1'b0);

    finish_run();
  end
endmodule